// File: doc/BRIEF.md
# I2C Transfer Bit-Rate Meter

This block sits beside an I2C bus monitor and measures how fast payload bits moved during one transfer segment. The monitor sends it single-cycle pulses. One pulse marks a start or repeated start. One marks each sampled bit, with a flag that says whether the bit is an acknowledge slot. One marks a stop. The monitor also supplies a free-running sample index and the configured sample rate in samples per second.

A segment opens at a start or repeated start. At that point the meter records the current sample index and clears its payload-bit count. When a stop closes the segment, the meter computes the elapsed samples, inclusive of both ends. It then latches the bit count, the sample rate and the elapsed count as operands for a sequential restoring divider. Once the quotient of count × rate ÷ elapsed is ready, the meter presents it for exactly one cycle. The result is an integer, and the fraction is discarded.

A repeated start restarts the window, so only the last segment before a stop is measured. Nothing is reported when no window is open, when the sample rate is zero, or when the elapsed count wraps to zero.

Top module: `i2c_rate_meter`

## Requirements
- R1: A pulse on `seg_start_i` (start or repeated start) opens a window. It records `sample_idx_i` as the window start and sets the bit count to zero, discarding any bits counted before.
- R2: While a window is open, each cycle with `bit_strobe_i`=1 and `bit_is_ack_i`=0 adds one to the bit count. The count saturates at 2^CNT_W−1.
- R3: A bit pulse with `bit_is_ack_i`=1 (an acknowledge slot) leaves the bit count unchanged.
- R4: At a stop, elapsed = (`sample_idx_i` − window start + 1) modulo 2^IDX_W. The reported value is floor(count × rate ÷ elapsed), where count is the value accumulated before the stop cycle and rate is `sample_rate_i` in the stop cycle.
- R5: `rate_valid_o` is high for exactly one cycle. It rises on the PROD_W-th rising clock edge after the edge that samples the stop. `rate_o` holds the result while `rate_valid_o` is high.
- R6: A stop produces no report if no window is open, if `sample_rate_i` is zero, or if the elapsed count is zero.
- R7: A stop closes the window and zeroes the count. A further stop with no start in between produces no report.
- R8: The divider operands are latched at the stop. Starts, bits and sample-rate changes during the division do not alter the result.
- R9: A stop that arrives while a division is running is not reported. It still closes the window.
- R10: When a start and a stop arrive in the same cycle, the stop is measured against the old window. A new window then opens at that cycle's sample index.
- R11: When a start and a payload bit arrive in the same cycle, the new window begins with a count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seg_start_i | input | 1 | Start or repeated-start pulse |
| bit_strobe_i | input | 1 | Bit-sampled pulse |
| bit_is_ack_i | input | 1 | Qualifies `bit_strobe_i` as an acknowledge slot |
| stop_i | input | 1 | Stop pulse |
| sample_idx_i | input | IDX_W (32) | Free-running sample index |
| sample_rate_i | input | SRATE_W (32) | Sample rate in samples per second; zero means unset |
| rate_o | output | CNT_W+SRATE_W (48) | Measured bit rate |
| rate_valid_o | output | 1 | One-cycle strobe marking `rate_o` valid |

## Verification
The bench builds the meter with its default parameters: a 32-bit sample index, a 32-bit sample rate and a 16-bit bit count. The product is therefore 48 bits wide, and each division takes 48 cycles.

These widths let the bench drive a window that wraps the sample index through zero. They also allow an elapsed count of 2^32−1 against the largest sample rate. Because 16 bits is small enough to reach in simulation, the bench holds the bit strobe high long enough to drive the count into saturation. The 48-cycle division window also leaves room to inject starts, stops and rate changes while the quotient is being formed.

// File: rtl/i2c_rate_pkg.sv
package i2c_rate_pkg;
  localparam int unsigned DEF_IDX_W   = 32;
  localparam int unsigned DEF_SRATE_W = 32;
  localparam int unsigned DEF_CNT_W   = 16;

  typedef enum logic {
    DIV_IDLE = 1'b0,
    DIV_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/i2c_rate_window.sv
module i2c_rate_window #(
  parameter int unsigned IDX_W = 32,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seg_start_i,
  input  logic             bit_strobe_i,
  input  logic             bit_is_ack_i,
  input  logic             stop_i,
  input  logic [IDX_W-1:0] sample_idx_i,
  output logic             open_o,
  output logic [IDX_W-1:0] start_idx_o,
  output logic [CNT_W-1:0] bit_cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic payload_bit;
  logic cnt_at_max;

  assign payload_bit = bit_strobe_i && !bit_is_ack_i && open_o;
  assign cnt_at_max  = (bit_cnt_o == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_o      <= 1'b0;
      start_idx_o <= '0;
      bit_cnt_o   <= '0;
    end else if (seg_start_i) begin
      open_o      <= 1'b1;
      start_idx_o <= sample_idx_i;
      bit_cnt_o   <= '0;
    end else if (stop_i) begin
      open_o      <= 1'b0;
      bit_cnt_o   <= '0;
    end else if (payload_bit && !cnt_at_max) begin
      bit_cnt_o   <= bit_cnt_o + 1'b1;
    end
  end

  assert_start_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
    seg_start_i |=> (open_o && bit_cnt_o == '0 && start_idx_o == $past(sample_idx_i)));

  assert_bit_counts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (open_o && bit_strobe_i && !bit_is_ack_i && !seg_start_i && !stop_i && bit_cnt_o != CNT_MAX)
      |=> bit_cnt_o == $past(bit_cnt_o) + 1'b1);

  assert_count_saturates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt_o == CNT_MAX && !seg_start_i && !stop_i) |=> bit_cnt_o == CNT_MAX);

  assert_ack_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_strobe_i && bit_is_ack_i && !seg_start_i && !stop_i) |=> $stable(bit_cnt_o));

  assert_stop_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !seg_start_i) |=> (!open_o && bit_cnt_o == '0));
endmodule

// File: rtl/i2c_rate_divider.sv
module i2c_rate_divider
  import i2c_rate_pkg::*;
#(
  parameter int unsigned NUM_W = 48,
  parameter int unsigned DEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [NUM_W-1:0] quot_o
);
  localparam int unsigned STEP_W = $clog2(NUM_W + 1);
  localparam logic [STEP_W-1:0] STEPS = STEP_W'(NUM_W);

  div_state_e        state_q;
  logic [STEP_W-1:0] steps_left_q;
  logic [NUM_W-1:0]  work_q;
  logic [DEN_W-1:0]  rem_q;
  logic [DEN_W-1:0]  den_q;
  logic [DEN_W:0]    trial;
  logic [DEN_W:0]    diff;
  logic              fits;
  logic              last_step;

  assign busy_o    = (state_q == DIV_RUN);
  assign quot_o    = work_q;
  assign trial     = {rem_q, work_q[NUM_W-1]};
  assign fits      = (trial >= {1'b0, den_q});
  assign diff      = trial - {1'b0, den_q};
  assign last_step = busy_o && (steps_left_q == STEP_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= DIV_IDLE;
      steps_left_q <= '0;
      work_q       <= '0;
      rem_q        <= '0;
      den_q        <= '0;
      done_o       <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (state_q == DIV_IDLE) begin
        if (launch_i) begin
          state_q      <= DIV_RUN;
          steps_left_q <= STEPS;
          work_q       <= num_i;
          rem_q        <= '0;
          den_q        <= den_i;
        end
      end else begin
        work_q       <= {work_q[NUM_W-2:0], fits};
        rem_q        <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        steps_left_q <= steps_left_q - 1'b1;
        if (last_step) begin
          state_q <= DIV_IDLE;
          done_o  <= 1'b1;
        end
      end
    end
  end

  assert_operands_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !last_step) |=> $stable(den_q));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_after_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> (done_o && !busy_o));
endmodule

// File: rtl/i2c_rate_meter.sv
module i2c_rate_meter
  import i2c_rate_pkg::*;
#(
  parameter int unsigned IDX_W   = DEF_IDX_W,
  parameter int unsigned SRATE_W = DEF_SRATE_W,
  parameter int unsigned CNT_W   = DEF_CNT_W,
  localparam int unsigned PROD_W = CNT_W + SRATE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               seg_start_i,
  input  logic               bit_strobe_i,
  input  logic               bit_is_ack_i,
  input  logic               stop_i,
  input  logic [IDX_W-1:0]   sample_idx_i,
  input  logic [SRATE_W-1:0] sample_rate_i,
  output logic [PROD_W-1:0]  rate_o,
  output logic               rate_valid_o
);
  function automatic logic [IDX_W-1:0] span_of(input logic [IDX_W-1:0] stop_idx,
                                               input logic [IDX_W-1:0] first_idx);
    return stop_idx - first_idx + IDX_W'(1);
  endfunction

  function automatic logic [PROD_W-1:0] bits_times_rate(input logic [CNT_W-1:0] nbits,
                                                        input logic [SRATE_W-1:0] srate);
    return PROD_W'(nbits) * PROD_W'(srate);
  endfunction

  logic               win_open;
  logic [IDX_W-1:0]   win_first;
  logic [CNT_W-1:0]   win_bits;
  logic [IDX_W-1:0]   span;
  logic [PROD_W-1:0]  product;
  logic               div_busy;
  logic               div_done;
  logic               stop_launch;
  logic               stop_guarded;

  i2c_rate_window #(
    .IDX_W (IDX_W),
    .CNT_W (CNT_W)
  ) u_window (
    .clk          (clk),
    .rst_n        (rst_n),
    .seg_start_i  (seg_start_i),
    .bit_strobe_i (bit_strobe_i),
    .bit_is_ack_i (bit_is_ack_i),
    .stop_i       (stop_i),
    .sample_idx_i (sample_idx_i),
    .open_o       (win_open),
    .start_idx_o  (win_first),
    .bit_cnt_o    (win_bits)
  );

  assign span         = span_of(sample_idx_i, win_first);
  assign product      = bits_times_rate(win_bits, sample_rate_i);
  assign stop_guarded = stop_i && (!win_open || sample_rate_i == '0 || span == '0);
  assign stop_launch  = stop_i && !div_busy && !stop_guarded;

  i2c_rate_divider #(
    .NUM_W (PROD_W),
    .DEN_W (IDX_W)
  ) u_divider (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch_i (stop_launch),
    .num_i    (product),
    .den_i    (span),
    .busy_o   (div_busy),
    .done_o   (div_done),
    .quot_o   (rate_o)
  );

  assign rate_valid_o = div_done;

  assert_guard_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !div_busy && stop_guarded) |=> !div_busy);

  assert_launch_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_launch |=> (div_busy && !rate_valid_o));

  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rate_valid_o |=> !rate_valid_o);

  assert_no_valid_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rate_valid_o |-> !div_busy);
endmodule

// File: tb/i2c_rate_meter_bench.sv
module i2c_rate_meter_bench;
  localparam int unsigned IDX_W   = 32;
  localparam int unsigned SRATE_W = 32;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned PROD_W  = CNT_W + SRATE_W;
  localparam int WD_LIMIT = 190000;

  typedef struct packed {
    logic [31:0] first;
    logic [15:0] nbits;
    logic [7:0]  nacks;
    logic [31:0] last;
    logic [31:0] srate;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{32'd100,         16'd9,  8'd2, 32'd199,         32'd1_000_000},
    '{32'd0,           16'd18, 8'd3, 32'd449,         32'd100_000_000},
    '{32'hFFFF_FFF0,   16'd16, 8'd2, 32'h0000_000F,   32'd1000},
    '{32'd7,           16'd0,  8'd1, 32'd7,           32'd12345},
    '{32'd10,          16'd7,  8'd1, 32'd12,          32'd10},
    '{32'd0,           16'd1,  8'd0, 32'hFFFF_FFFE,   32'hFFFF_FFFF}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              seg_start = 1'b0;
  logic              bit_strobe = 1'b0;
  logic              bit_ack = 1'b0;
  logic              stop = 1'b0;
  logic [IDX_W-1:0]  sample_idx = '0;
  logic [SRATE_W-1:0] sample_rate = '0;
  logic [PROD_W-1:0] rate;
  logic              rate_valid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  i2c_rate_meter u_i2c_rate_meter (
    .clk           (clk),
    .rst_n         (rst_n),
    .seg_start_i   (seg_start),
    .bit_strobe_i  (bit_strobe),
    .bit_is_ack_i  (bit_ack),
    .stop_i        (stop),
    .sample_idx_i  (sample_idx),
    .sample_rate_i (sample_rate),
    .rate_o        (rate),
    .rate_valid_o  (rate_valid)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WD_LIMIT) begin
      errors = errors + 1;
      $display("FAIL watchdog (all requirements): actual %0d cycles, expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic longint unsigned model_rate(input logic [31:0] first, input logic [31:0] last,
                                                 input longint unsigned nbits, input logic [31:0] srate);
    logic [31:0] el;
    el = last - first + 32'd1;
    return (nbits * longint'(srate)) / longint'(el);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_start(input logic [31:0] idx);
    seg_start = 1'b1; sample_idx = idx; tick(); seg_start = 1'b0;
  endtask

  task automatic do_bit(input logic is_ack);
    bit_strobe = 1'b1; bit_ack = is_ack; tick(); bit_strobe = 1'b0; bit_ack = 1'b0;
  endtask

  task automatic do_stop(input logic [31:0] idx, input logic [31:0] srate);
    stop = 1'b1; sample_idx = idx; sample_rate = srate; tick(); stop = 1'b0;
  endtask

  // Called right after the stop edge; waits for the strobe and measures its latency.
  task automatic wait_report(output bit got, output longint unsigned val, output int lat);
    got = 1'b0; val = 0; lat = 0;
    for (int n = 1; n <= 120; n++) begin
      tick();
      if (rate_valid && !got) begin
        got = 1'b1; val = longint'(rate); lat = n;
        tick();
        check(!rate_valid, "R5", "strobe width", longint'(rate_valid), 0);
        break;
      end
    end
  endtask

  task automatic count_reports(input int span_cyc, output int n_rep, output longint unsigned last_val);
    n_rep = 0; last_val = 0;
    for (int n = 0; n < span_cyc; n++) begin
      tick();
      if (rate_valid) begin
        n_rep = n_rep + 1; last_val = longint'(rate);
      end
    end
  endtask

  initial begin
    bit got;
    longint unsigned val;
    longint unsigned exp;
    int lat;
    int nrep;

    tick(); tick();
    check(rate_valid == 1'b0, "R5", "reset valid", longint'(rate_valid), 0);
    check(rate == '0, "R5", "reset rate", longint'(rate), 0);
    rst_n = 1'b1;
    tick();

    // Table walk: R1 R2 R3 R4 R5
    for (int v = 0; v < NVEC; v++) begin
      do_start(VECS[v].first);
      for (int b = 0; b < int'(VECS[v].nbits); b++) begin
        do_bit(1'b0);
        if (b < int'(VECS[v].nacks)) do_bit(1'b1);
      end
      do_stop(VECS[v].last, VECS[v].srate);
      wait_report(got, val, lat);
      exp = model_rate(VECS[v].first, VECS[v].last, longint'(VECS[v].nbits), VECS[v].srate);
      check(got && val == exp, "R4", $sformatf("vector %0d rate", v), val, exp);
      check(lat == int'(PROD_W), "R5", $sformatf("vector %0d latency", v), longint'(lat), PROD_W);
    end

    // R6: zero sample rate
    do_start(32'd50); do_bit(1'b0); do_bit(1'b0);
    do_stop(32'd99, 32'd0);
    count_reports(100, nrep, val);
    check(nrep == 0, "R6", "zero rate reports", longint'(nrep), 0);

    // R6 and R7: stop with no window open (window closed by previous stop)
    do_stop(32'd500, 32'd1000);
    count_reports(100, nrep, val);
    check(nrep == 0, "R7", "stop without window", longint'(nrep), 0);

    // R6: elapsed count wraps to zero
    do_start(32'd5); do_bit(1'b0);
    do_stop(32'd4, 32'd1000);
    count_reports(100, nrep, val);
    check(nrep == 0, "R6", "zero elapsed reports", longint'(nrep), 0);

    // R1: repeated start restarts window and count
    do_start(32'd1000);
    for (int b = 0; b < 5; b++) do_bit(1'b0);
    do_start(32'd2000);
    for (int b = 0; b < 3; b++) do_bit(1'b0);
    do_stop(32'd2099, 32'd1_000_000);
    wait_report(got, val, lat);
    exp = model_rate(32'd2000, 32'd2099, 3, 32'd1_000_000);
    check(got && val == exp, "R1", "repeated start window", val, exp);

    // R11: start and payload bit in the same cycle
    seg_start = 1'b1; bit_strobe = 1'b1; sample_idx = 32'd300; tick();
    seg_start = 1'b0; bit_strobe = 1'b0;
    for (int b = 0; b < 3; b++) do_bit(1'b0);
    do_stop(32'd399, 32'd1000);
    wait_report(got, val, lat);
    exp = model_rate(32'd300, 32'd399, 3, 32'd1000);
    check(got && val == exp, "R11", "start plus bit", val, exp);

    // R10: start and stop in the same cycle
    do_start(32'd1000);
    for (int b = 0; b < 4; b++) do_bit(1'b0);
    seg_start = 1'b1; stop = 1'b1; sample_idx = 32'd1999; sample_rate = 32'd50_000_000; tick();
    seg_start = 1'b0; stop = 1'b0;
    wait_report(got, val, lat);
    exp = model_rate(32'd1000, 32'd1999, 4, 32'd50_000_000);
    check(got && val == exp, "R10", "old window measured", val, exp);
    do_bit(1'b0); do_bit(1'b0);
    do_stop(32'd2998, 32'd50_000_000);
    wait_report(got, val, lat);
    exp = model_rate(32'd1999, 32'd2998, 2, 32'd50_000_000);
    check(got && val == exp, "R10", "new window opened", val, exp);

    // R8 and R9: activity during a running division
    do_start(32'd0);
    for (int b = 0; b < 8; b++) do_bit(1'b0);
    do_stop(32'd799, 32'd400_000);
    sample_rate = 32'd7;
    do_start(32'd900);
    for (int b = 0; b < 4; b++) do_bit(1'b0);
    do_stop(32'd950, 32'd123_456);
    count_reports(110, nrep, val);
    exp = model_rate(32'd0, 32'd799, 8, 32'd400_000);
    check(nrep == 1, "R9", "reports during busy", longint'(nrep), 1);
    check(val == exp, "R8", "latched operands", val, exp);
    do_stop(32'd1200, 32'd1000);
    count_reports(100, nrep, val);
    check(nrep == 0, "R9", "dropped stop closed window", longint'(nrep), 0);

    // R2: count saturation
    do_start(32'd0);
    bit_strobe = 1'b1;
    for (int b = 0; b < 65540; b++) tick();
    bit_strobe = 1'b0;
    do_stop(32'd100_000, 32'd1_000_000);
    wait_report(got, val, lat);
    exp = model_rate(32'd0, 32'd100_000, 65535, 32'd1_000_000);
    check(got && val == exp, "R2", "saturated count", val, exp);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule